// File: doc/BRIEF.md
# Linear CCD Drive Timing Generator

This block turns one fast system clock into the digital drive waveforms for a linear CCD line sensor that has an odd-pixel output and an even-pixel output. Each line starts with a frozen window. In that window the two transfer phases are held, with phase 1 high. A transfer-gate pulse is placed inside the window, with a guard interval before it and a guard interval after it. This pulse moves the charge from the photodiodes into the analog shift registers. Then the two complementary transfer phases run for the programmed number of transfer periods. A transfer period is two pixel slots of `SLOT_CLKS` system clocks each. The odd-channel reset clock pulses at the start of every phase-1 slot, and the even-channel reset clock pulses at the start of every phase-2 slot.

The line length, counted in transfer periods, sets the integration time. This is the spacing between two transfer-gate pulses. The line length is forced up to at least `MIN_PERIODS`. The reset pulse width is given in system clocks. The block samples both values once per line, on the last clock of the setup guard. A value written at any other time is therefore held off until the next line. A one-cycle start-of-line strobe marks the first transfer period, and a one-cycle line-done flag marks the final clock of the last period. Every output comes straight from a flip-flop.

Top module: `ccd_drive_tg`

## Requirements
- R1: While `rst` is high, every output is held low except `phi1_o`, which is held high.
- R2: Each line starts with `SETUP_CLKS` clocks in which `phi1_o` is 1, `phi2_o` is 0 and `sg_o` is 0. Next come `GATE_CLKS` clocks with `sg_o` at 1, and then `HOLD_CLKS` clocks with `sg_o` at 0. The phases stay frozen and both reset clocks stay low through all three intervals.
- R3: After the hold guard, every transfer period lasts 2×`SLOT_CLKS` clocks. `phi1_o` is high for the first `SLOT_CLKS` clocks and `phi2_o` is high for the second `SLOT_CLKS` clocks. The two phases are never equal.
- R4: A line runs exactly max(`line_len_i`, `MIN_PERIODS`) transfer periods. The setup guard of the next line follows at once.
- R5: `line_len_i` and `rst_width_i` are sampled only on the last clock of the setup guard. A change at any other time has no effect on the line in progress.
- R6: With W equal to `rst_width_i`, `rs_odd_o` is high for the first W clocks of each phase-1 slot and `rs_even_o` is high for the first W clocks of each phase-2 slot. If `rst_width_i` is 0, W is `RST_W_DEF` instead. W is limited to `SLOT_CLKS`-1.
- R7: `sol_o` is high for exactly one clock, on the first clock of the first transfer period. That clock is also the first clock of the first `rs_odd_o` pulse.
- R8: `line_done_o` is high for exactly one clock, on the final clock of the last transfer period. The next clock is the first clock of the next setup guard.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| line_len_i | input | LEN_W | Transfer periods per line, sampled once per line |
| rst_width_i | input | TICK_W | Reset pulse width in system clocks; 0 selects the default width |
| phi1_o | output | 1 | Transfer phase 1 |
| phi2_o | output | 1 | Transfer phase 2 |
| sg_o | output | 1 | Transfer-gate pulse |
| rs_odd_o | output | 1 | Reset clock for the odd-pixel output |
| rs_even_o | output | 1 | Reset clock for the even-pixel output |
| sol_o | output | 1 | Start-of-line strobe |
| line_done_o | output | 1 | Last clock of the line |

## Verification
The start-of-line strobe and the first odd-channel reset pulse come from separate decode paths, but they must rise in the same clock. Every line therefore exercises both at once. The bench predicts, for every clock of each line, the level of `sol_o` and the level of `rs_odd_o`, and judges each field separately at that clock. A checker property also requires the reset pulse to be present whenever the strobe is. The lines are run with different pulse widths, and one width is large enough to be clamped, so the coincidence is checked whether the odd-channel pulse is one clock wide or several.

// File: rtl/ccd_tg_pkg.sv
package ccd_tg_pkg;

  typedef enum logic [1:0] {
    SEQ_SETUP = 2'd0,
    SEQ_GATE  = 2'd1,
    SEQ_HOLD  = 2'd2,
    SEQ_RUN   = 2'd3
  } seq_state_e;

  function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ccd_tg_seq.sv
module ccd_tg_seq
  import ccd_tg_pkg::*;
#(
  parameter int unsigned SETUP_CLKS  = 20,
  parameter int unsigned GATE_CLKS   = 86,
  parameter int unsigned HOLD_CLKS   = 24,
  parameter int unsigned SLOT_CLKS   = 24,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned MIN_PERIODS = 5021,
  localparam int unsigned TICK_W     = $clog2(2 * SLOT_CLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  line_len_i,
  output seq_state_e        st_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              first_per_o,
  output logic              last_per_o,
  output logic              latch_o
);

  localparam int unsigned WIN_MAX = max3(SETUP_CLKS, GATE_CLKS, HOLD_CLKS);
  localparam int unsigned WIN_W   = $clog2(WIN_MAX + 1);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(2 * SLOT_CLKS - 1);
  localparam logic [LEN_W-1:0]  LEN_MIN   = LEN_W'(MIN_PERIODS);

  seq_state_e        st;
  logic [WIN_W-1:0]  win_cnt;
  logic [TICK_W-1:0] tick;
  logic [LEN_W-1:0]  per_cnt;
  logic [LEN_W-1:0]  len_q;
  logic [LEN_W-1:0]  len_eff;
  logic              per_last;

  assign len_eff  = (line_len_i < LEN_MIN) ? LEN_MIN : line_len_i;
  assign per_last = (per_cnt == len_q - LEN_W'(1));
  assign latch_o  = (st == SEQ_SETUP) && (win_cnt == WIN_W'(SETUP_CLKS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= SEQ_SETUP;
      win_cnt <= '0;
      tick    <= '0;
      per_cnt <= '0;
      len_q   <= LEN_MIN;
    end else begin
      unique case (st)
        SEQ_SETUP: begin
          if (latch_o) begin
            st      <= SEQ_GATE;
            win_cnt <= '0;
            len_q   <= len_eff;
          end else begin
            win_cnt <= win_cnt + WIN_W'(1);
          end
        end
        SEQ_GATE: begin
          if (win_cnt == WIN_W'(GATE_CLKS - 1)) begin
            st      <= SEQ_HOLD;
            win_cnt <= '0;
          end else begin
            win_cnt <= win_cnt + WIN_W'(1);
          end
        end
        SEQ_HOLD: begin
          if (win_cnt == WIN_W'(HOLD_CLKS - 1)) begin
            st      <= SEQ_RUN;
            win_cnt <= '0;
            tick    <= '0;
            per_cnt <= '0;
          end else begin
            win_cnt <= win_cnt + WIN_W'(1);
          end
        end
        SEQ_RUN: begin
          if (tick == TICK_LAST) begin
            tick <= '0;
            if (per_last) begin
              st      <= SEQ_SETUP;
              win_cnt <= '0;
            end else begin
              per_cnt <= per_cnt + LEN_W'(1);
            end
          end else begin
            tick <= tick + TICK_W'(1);
          end
        end
        default: st <= SEQ_SETUP;
      endcase
    end
  end

  assign st_o        = st;
  assign tick_o      = tick;
  assign first_per_o = (per_cnt == '0);
  assign last_per_o  = per_last;

endmodule

// File: rtl/ccd_tg_rstgen.sv
module ccd_tg_rstgen
  import ccd_tg_pkg::*;
#(
  parameter int unsigned SLOT_CLKS = 24,
  parameter int unsigned RST_W_DEF = 7,
  localparam int unsigned TICK_W   = $clog2(2 * SLOT_CLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              latch_i,
  input  logic [TICK_W-1:0] width_i,
  input  seq_state_e        st_i,
  input  logic [TICK_W-1:0] tick_i,
  output logic [1:0]        rs_d_o
);

  localparam int unsigned W_MAX = SLOT_CLKS - 1;
  localparam int unsigned W_DEF = (RST_W_DEF < 1) ? 1 :
                                  ((RST_W_DEF > W_MAX) ? W_MAX : RST_W_DEF);
  localparam logic [TICK_W-1:0] SLOT_T = TICK_W'(SLOT_CLKS);

  logic [TICK_W-1:0] w_q;
  logic [TICK_W-1:0] w_next;
  logic              half;
  logic [TICK_W-1:0] off;
  logic              run;

  always_comb begin
    if (width_i == '0)
      w_next = TICK_W'(W_DEF);
    else if (width_i > TICK_W'(W_MAX))
      w_next = TICK_W'(W_MAX);
    else
      w_next = width_i;
  end

  always_ff @(posedge clk) begin
    if (rst)
      w_q <= TICK_W'(W_DEF);
    else if (latch_i)
      w_q <= w_next;
  end

  assign run  = (st_i == SEQ_RUN);
  assign half = (tick_i >= SLOT_T);
  assign off  = half ? (tick_i - SLOT_T) : tick_i;

  for (genvar ch = 0; ch < 2; ch++) begin : g_chan
    assign rs_d_o[ch] = run && (half == ch[0]) && (off < w_q);
  end

endmodule

// File: rtl/ccd_tg_outreg.sv
module ccd_tg_outreg
  import ccd_tg_pkg::*;
#(
  parameter int unsigned SLOT_CLKS = 24,
  localparam int unsigned TICK_W   = $clog2(2 * SLOT_CLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  seq_state_e        st_i,
  input  logic [TICK_W-1:0] tick_i,
  input  logic              first_per_i,
  input  logic              last_per_i,
  input  logic [1:0]        rs_d_i,
  output logic              phi1_o,
  output logic              phi2_o,
  output logic              sg_o,
  output logic              rs_odd_o,
  output logic              rs_even_o,
  output logic              sol_o,
  output logic              done_o
);

  localparam logic [TICK_W-1:0] SLOT_T    = TICK_W'(SLOT_CLKS);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(2 * SLOT_CLKS - 1);

  logic run;
  logic lo_half;

  assign run     = (st_i == SEQ_RUN);
  assign lo_half = (tick_i < SLOT_T);

  always_ff @(posedge clk) begin
    if (rst) begin
      phi1_o    <= 1'b1;
      phi2_o    <= 1'b0;
      sg_o      <= 1'b0;
      rs_odd_o  <= 1'b0;
      rs_even_o <= 1'b0;
      sol_o     <= 1'b0;
      done_o    <= 1'b0;
    end else begin
      phi1_o    <= run ? lo_half : 1'b1;
      phi2_o    <= run && !lo_half;
      sg_o      <= (st_i == SEQ_GATE);
      rs_odd_o  <= rs_d_i[0];
      rs_even_o <= rs_d_i[1];
      sol_o     <= run && first_per_i && (tick_i == '0);
      done_o    <= run && last_per_i && (tick_i == TICK_LAST);
    end
  end

endmodule

// File: rtl/ccd_drive_tg.sv
module ccd_drive_tg
  import ccd_tg_pkg::*;
#(
  parameter int unsigned SETUP_CLKS  = 20,
  parameter int unsigned GATE_CLKS   = 86,
  parameter int unsigned HOLD_CLKS   = 24,
  parameter int unsigned SLOT_CLKS   = 24,
  parameter int unsigned LEN_W       = 16,
  parameter int unsigned MIN_PERIODS = 5021,
  parameter int unsigned RST_W_DEF   = 7,
  localparam int unsigned TICK_W     = $clog2(2 * SLOT_CLKS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LEN_W-1:0]  line_len_i,
  input  logic [TICK_W-1:0] rst_width_i,
  output logic              phi1_o,
  output logic              phi2_o,
  output logic              sg_o,
  output logic              rs_odd_o,
  output logic              rs_even_o,
  output logic              sol_o,
  output logic              line_done_o
);

  seq_state_e        st;
  logic [TICK_W-1:0] tick;
  logic              first_per;
  logic              last_per;
  logic              latch;
  logic [1:0]        rs_d;

  ccd_tg_seq #(
    .SETUP_CLKS (SETUP_CLKS),
    .GATE_CLKS  (GATE_CLKS),
    .HOLD_CLKS  (HOLD_CLKS),
    .SLOT_CLKS  (SLOT_CLKS),
    .LEN_W      (LEN_W),
    .MIN_PERIODS(MIN_PERIODS)
  ) u_seq (
    .clk        (clk),
    .rst        (rst),
    .line_len_i (line_len_i),
    .st_o       (st),
    .tick_o     (tick),
    .first_per_o(first_per),
    .last_per_o (last_per),
    .latch_o    (latch)
  );

  ccd_tg_rstgen #(
    .SLOT_CLKS(SLOT_CLKS),
    .RST_W_DEF(RST_W_DEF)
  ) u_rst (
    .clk    (clk),
    .rst    (rst),
    .latch_i(latch),
    .width_i(rst_width_i),
    .st_i   (st),
    .tick_i (tick),
    .rs_d_o (rs_d)
  );

  ccd_tg_outreg #(
    .SLOT_CLKS(SLOT_CLKS)
  ) u_out (
    .clk        (clk),
    .rst        (rst),
    .st_i       (st),
    .tick_i     (tick),
    .first_per_i(first_per),
    .last_per_i (last_per),
    .rs_d_i     (rs_d),
    .phi1_o     (phi1_o),
    .phi2_o     (phi2_o),
    .sg_o       (sg_o),
    .rs_odd_o   (rs_odd_o),
    .rs_even_o  (rs_even_o),
    .sol_o      (sol_o),
    .done_o     (line_done_o)
  );

endmodule

// File: rtl/ccd_drive_tg_chk.sv
module ccd_drive_tg_chk (
  input logic clk,
  input logic rst,
  input logic phi1_o,
  input logic phi2_o,
  input logic sg_o,
  input logic rs_odd_o,
  input logic rs_even_o,
  input logic sol_o,
  input logic line_done_o
);

  AST_PHASE_COMPL: assert property (@(posedge clk) disable iff (rst)
    phi1_o != phi2_o); // R3

  AST_SG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    sg_o |-> (phi1_o && !phi2_o)); // R2

  AST_SG_NO_RESET: assert property (@(posedge clk) disable iff (rst)
    sg_o |-> (!rs_odd_o && !rs_even_o)); // R2

  AST_RS_ODD_IN_PHI1: assert property (@(posedge clk) disable iff (rst)
    rs_odd_o |-> phi1_o); // R6

  AST_RS_EVEN_IN_PHI2: assert property (@(posedge clk) disable iff (rst)
    rs_even_o |-> phi2_o); // R6

  AST_RS_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rs_odd_o, rs_even_o})); // R6

  AST_SOL_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    sol_o |=> !sol_o); // R7

  AST_SOL_WITH_RS_ODD: assert property (@(posedge clk) disable iff (rst)
    sol_o |-> rs_odd_o); // R7

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    line_done_o |=> !line_done_o); // R8

  AST_DONE_IN_PHI2: assert property (@(posedge clk) disable iff (rst)
    line_done_o |-> phi2_o); // R8

  AST_DONE_THEN_FREEZE: assert property (@(posedge clk) disable iff (rst)
    line_done_o |=> (phi1_o && !phi2_o && !sg_o)); // R8

endmodule

bind ccd_drive_tg ccd_drive_tg_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .phi1_o     (phi1_o),
  .phi2_o     (phi2_o),
  .sg_o       (sg_o),
  .rs_odd_o   (rs_odd_o),
  .rs_even_o  (rs_even_o),
  .sol_o      (sol_o),
  .line_done_o(line_done_o)
);

// File: tb/sim_ccd_drive_tg.sv
module sim_ccd_drive_tg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int S    = 3;
  localparam int G    = 5;
  localparam int H    = 2;
  localparam int SLOT = 4;
  localparam int MINP = 6;
  localparam int WDEF = 1;

  typedef struct {
    logic [6:0] v;
    string      ptag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] line_len = 8'd7;
  logic [2:0] rw = 3'd2;
  logic phi1, phi2, sg, rso, rse, sol, done;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  ccd_drive_tg #(
    .SETUP_CLKS(S), .GATE_CLKS(G), .HOLD_CLKS(H), .SLOT_CLKS(SLOT),
    .LEN_W(8), .MIN_PERIODS(MINP), .RST_W_DEF(WDEF)
  ) u0 (
    .clk(clk), .rst(rst), .line_len_i(line_len), .rst_width_i(rw),
    .phi1_o(phi1), .phi2_o(phi2), .sg_o(sg), .rs_odd_o(rso),
    .rs_even_o(rse), .sol_o(sol), .line_done_o(done)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", tag, what, act, exp, $time);
    end
  endtask

  // driver: expected per-clock output vectors {phi1,phi2,sg,rso,rse,sol,done}
  task automatic push_line(input int n, input int w, input string ptag);
    exp_t e;
    for (int i = 0; i < S + G + H; i++) begin
      e.v = {1'b1, 1'b0, 1'(i >= S && i < S + G), 4'b0000};
      e.ptag = "R2";
      q.push_back(e);
    end
    for (int p = 0; p < n; p++) begin
      for (int t = 0; t < 2 * SLOT; t++) begin
        e.v = {1'(t < SLOT), 1'(t >= SLOT), 1'b0,
               1'(t < w), 1'(t >= SLOT && (t - SLOT) < w),
               1'(p == 0 && t == 0), 1'(p == n - 1 && t == 2 * SLOT - 1)};
        e.ptag = ptag;
        q.push_back(e);
      end
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired, queue left=%0d", q.size());
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk("R1", "phi1", phi1, 1);
    chk("R1", "phi2", phi2, 0);
    chk("R1", "sg", sg, 0);
    chk("R1", "rs_odd", rso, 0);
    chk("R1", "rs_even", rse, 0);
    chk("R1", "sol", sol, 0);
    chk("R1", "line_done", done, 0);

    // line1: 7 periods, width 2 (mid-line write must not alter it: R5)
    push_line(7, 2, "R5");
    // line2: length 3 clamped to MIN (R4), width 0 -> default
    push_line(MINP, WDEF, "R4");
    // line3: 9 periods, width 7 clamped to SLOT-1
    push_line(9, SLOT - 1, "R3");
    // line4: minimum length, width 3
    push_line(6, 3, "R3");

    rst = 1'b0;
    fork
      begin : stim
        repeat (12) @(negedge clk);
        line_len = 8'd3;  rw = 3'd0;
        repeat (66) @(negedge clk);
        line_len = 8'd9;  rw = 3'd7;
        repeat (58) @(negedge clk);
        line_len = 8'd6;  rw = 3'd3;
      end
      begin : monitor
        while (q.size() > 0) begin
          exp_t e;
          @(negedge clk);
          e = q.pop_front();
          chk(e.ptag, "phi1", phi1, int'(e.v[6]));
          chk(e.ptag, "phi2", phi2, int'(e.v[5]));
          chk("R2", "sg", sg, int'(e.v[4]));
          chk("R6", "rs_odd", rso, int'(e.v[3]));
          chk("R6", "rs_even", rse, int'(e.v[2]));
          chk("R7", "sol", sol, int'(e.v[1]));
          chk("R8", "line_done", done, int'(e.v[0]));
        end
      end
    join
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule